// File: doc/BRIEF.md
# JTAG Scan Chain Routing Multiplexer

This block sits between one external JTAG port and two internal scan targets: a routing switch and a processor core. It has a small TAP controller of its own, and that controller holds a select register written over JTAG. The select value decides which target receives the test-mode line and whose serial output comes back on the external TDO. Every target that is not selected sees a test-mode line held high, which keeps it parked in its reset state.

Reaching a target takes two steps. First the controller's route instruction is loaded and a select code is scanned in while the controller is alone on the chain. Then, once the Update-DR state takes effect, scanning runs through the chosen target. When no target is chosen, only the controller is on the chain. Its short registers can then be read back by a host that knows nothing about the data register lengths downstream. Code 0000 chooses no target, 0001 chooses the switch, and any code with bit 3 set chooses the core. Every other code chooses no target, so older software keeps working.

Top module: `jtag_route_mux`

## Requirements
- R1: While trst_n is low, the select register is 0000, tms_sw and tms_core are both 1, and tdo is 0.
- R2: The controller follows the standard 16-state TAP graph on the rising edge of tck. Five tck cycles with tms high reach Test-Logic-Reset from any state. Entering Test-Logic-Reset clears the select register to 0000 and loads the instruction register with all ones (bypass).
- R3: The instruction register is 4 bits wide and is shifted LSB first from tdi toward tdo. Capture-IR loads 0001. Opcode 0010 selects the 4-bit route register. Every other opcode selects a 1-bit bypass register that captures 0.
- R4: The select register changes only on the tck edge that leaves Update-DR, and only when the route instruction is active. The routing of tms and tdo never changes during Shift-DR.
- R5: Select code 0001 routes the switch: tms_sw follows tms, tms_core stays 1, and tdo equals tdo_sw.
- R6: A select code with bit 3 set routes the core whatever bits 2..0 hold: tms_core follows tms, tms_sw stays 1, and tdo equals tdo_core.
- R7: Codes 0000 and 0010 through 0111 route no target. Both gated tms outputs stay 1, and tdo comes only from the controller.
- R8: Capture-DR of the route register loads the current select value, so the value written last can be read back on the next route scan.
- R9: When no target is routed, tdo changes on the falling edge of tck. It carries the bit at the LSB of the active register in Shift-IR and Shift-DR, and is 0 in every other state.
- R10: Once a target is routed, further route-register updates are ignored. The routing holds until Test-Logic-Reset or trst_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | External test-mode select |
| tdi | input | 1 | External serial data in |
| tdo_sw | input | 1 | Serial output of the switch target |
| tdo_core | input | 1 | Serial output of the core target |
| tms_sw | output | 1 | Gated test-mode line to the switch target |
| tms_core | output | 1 | Gated test-mode line to the core target |
| tdo | output | 1 | External serial data out |

## Verification
The bench builds the block with its default parameters: a 4-bit select register, a 4-bit instruction register and route opcode 0010. With these values every decode class is reached in a few scan sequences: the switch code, core codes with different low bits, and unassigned codes. Because the controller captures the select value, each code written while unrouted is read back on the next scan. Throughout, the gated tms lines and tdo are compared each cycle with a behavioural routing model, while the target outputs carry pseudo-random noise.

// File: rtl/jtag_route_pkg.sv
package jtag_route_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EX1_DR, TS_PAUSE_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EX1_IR, TS_PAUSE_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    function automatic tap_state_e tap_step(input tap_state_e s, input logic m);
        tap_state_e r;
        case (s)
            TS_RESET:    r = m ? TS_RESET    : TS_IDLE;
            TS_IDLE:     r = m ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   r = m ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   r = m ? TS_EX1_DR   : TS_SHIFT_DR;
            TS_SHIFT_DR: r = m ? TS_EX1_DR   : TS_SHIFT_DR;
            TS_EX1_DR:   r = m ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: r = m ? TS_EX2_DR   : TS_PAUSE_DR;
            TS_EX2_DR:   r = m ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   r = m ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   r = m ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   r = m ? TS_EX1_IR   : TS_SHIFT_IR;
            TS_SHIFT_IR: r = m ? TS_EX1_IR   : TS_SHIFT_IR;
            TS_EX1_IR:   r = m ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: r = m ? TS_EX2_IR   : TS_PAUSE_IR;
            TS_EX2_IR:   r = m ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   r = m ? TS_SEL_DR   : TS_IDLE;
            default:     r = TS_RESET;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/jtag_route_tap.sv
module jtag_route_tap
    import jtag_route_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q,
    output tap_state_e state_d
);

    typedef struct packed {
        tap_state_e st;
    } tap_regs_t;

    tap_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.st = tap_step(r_q.st, tms);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{st: TS_RESET};
        else         r_q <= r_d;
    end

    assign state_q = r_q.st;
    assign state_d = r_d.st;

endmodule

// File: rtl/jtag_route_regs.sv
module jtag_route_regs
    import jtag_route_pkg::*;
#(
    parameter int                IR_W      = 4,
    parameter int                SEL_W     = 4,
    parameter logic [IR_W-1:0]   ROUTE_OPC = IR_W'(2)
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  tap_state_e       state_q,
    input  tap_state_e       state_d,
    input  logic             route_idle,
    output logic [SEL_W-1:0] sel_q,
    output logic             shift_bit
);

    localparam logic [IR_W-1:0] BYP_OPC = {IR_W{1'b1}};
    localparam logic [IR_W-1:0] IR_CAP  = IR_W'(1);

    typedef struct packed {
        logic [IR_W-1:0]  ir_sr;
        logic [IR_W-1:0]  ir;
        logic [SEL_W-1:0] dr_sr;
        logic             byp;
        logic [SEL_W-1:0] sel;
    } regs_t;

    regs_t r_d, r_q;
    logic  route_sel;

    assign route_sel = (r_q.ir == ROUTE_OPC);

    always_comb begin
        r_d = r_q;
        case (state_q)
            TS_RESET:    r_d.ir    = BYP_OPC;
            TS_CAP_IR:   r_d.ir_sr = IR_CAP;
            TS_SHIFT_IR: r_d.ir_sr = {tdi, r_q.ir_sr[IR_W-1:1]};
            TS_UPD_IR:   r_d.ir    = r_q.ir_sr;
            TS_CAP_DR: begin
                if (route_sel) r_d.dr_sr = r_q.sel;
                else           r_d.byp   = 1'b0;
            end
            TS_SHIFT_DR: begin
                if (route_sel) r_d.dr_sr = {tdi, r_q.dr_sr[SEL_W-1:1]};
                else           r_d.byp   = tdi;
            end
            TS_UPD_DR: begin
                // routing is frozen while a target is on the chain
                if (route_sel && route_idle) r_d.sel = r_q.dr_sr;
            end
            default: ;
        endcase
        if (state_d == TS_RESET) r_d.sel = '0;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{ir_sr: '0, ir: BYP_OPC, dr_sr: '0, byp: 1'b0, sel: '0};
        else         r_q <= r_d;
    end

    always_comb begin
        if (state_q == TS_SHIFT_IR) shift_bit = r_q.ir_sr[0];
        else if (route_sel)         shift_bit = r_q.dr_sr[0];
        else                        shift_bit = r_q.byp;
    end

    assign sel_q = r_q.sel;

endmodule

// File: rtl/jtag_route_port.sv
module jtag_route_port
    import jtag_route_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  tap_state_e       state_q,
    input  logic             shift_bit,
    input  logic [SEL_W-1:0] sel_q,
    input  logic             tdo_sw,
    input  logic             tdo_core,
    output logic             tms_sw,
    output logic             tms_core,
    output logic             tdo,
    output logic             route_idle
);

    localparam int N_TGT    = 2;
    localparam int TGT_SW   = 0;
    localparam int TGT_CORE = 1;

    typedef struct packed {
        logic tdo;
    } out_regs_t;

    out_regs_t        o_d, o_q;
    logic [N_TGT-1:0] hit;
    logic [N_TGT-1:0] tgt_tdo;
    logic [N_TGT-1:0] tgt_tms;

    // bit 3 wins; code 0001 has bit 3 clear, so hits are one-hot
    assign hit[TGT_SW]       = (sel_q == SEL_W'(1));
    assign hit[TGT_CORE]     = sel_q[SEL_W-1];
    assign route_idle        = ~|hit;
    assign tgt_tdo[TGT_SW]   = tdo_sw;
    assign tgt_tdo[TGT_CORE] = tdo_core;

    for (genvar g = 0; g < N_TGT; g++) begin : g_gate
        assign tgt_tms[g] = hit[g] ? tms : 1'b1;
    end

    always_comb begin
        o_d     = o_q;
        o_d.tdo = ((state_q == TS_SHIFT_IR) || (state_q == TS_SHIFT_DR)) ? shift_bit : 1'b0;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) o_q <= '{tdo: 1'b0};
        else         o_q <= o_d;
    end

    assign tms_sw   = tgt_tms[TGT_SW];
    assign tms_core = tgt_tms[TGT_CORE];
    assign tdo      = route_idle ? o_q.tdo : |(hit & tgt_tdo);

endmodule

// File: rtl/jtag_route_mux.sv
module jtag_route_mux
    import jtag_route_pkg::*;
#(
    parameter int              IR_W      = 4,
    parameter int              SEL_W     = 4,
    parameter logic [IR_W-1:0] ROUTE_OPC = IR_W'(2)
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    input  logic tdo_sw,
    input  logic tdo_core,
    output logic tms_sw,
    output logic tms_core,
    output logic tdo
);

    tap_state_e       tap_state;
    tap_state_e       tap_next;
    logic [SEL_W-1:0] sel_cur;
    logic             shift_bit;
    logic             route_idle;

    jtag_route_tap u_tap (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_q (tap_state),
        .state_d (tap_next)
    );

    jtag_route_regs #(
        .IR_W      (IR_W),
        .SEL_W     (SEL_W),
        .ROUTE_OPC (ROUTE_OPC)
    ) u_regs (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .state_q    (tap_state),
        .state_d    (tap_next),
        .route_idle (route_idle),
        .sel_q      (sel_cur),
        .shift_bit  (shift_bit)
    );

    jtag_route_port #(
        .SEL_W (SEL_W)
    ) u_port (
        .tck        (tck),
        .trst_n     (trst_n),
        .tms        (tms),
        .state_q    (tap_state),
        .shift_bit  (shift_bit),
        .sel_q      (sel_cur),
        .tdo_sw     (tdo_sw),
        .tdo_core   (tdo_core),
        .tms_sw     (tms_sw),
        .tms_core   (tms_core),
        .tdo        (tdo),
        .route_idle (route_idle)
    );

endmodule

// File: rtl/jtag_route_chk.sv
module jtag_route_chk
    import jtag_route_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input logic             tck,
    input logic             trst_n,
    input logic             tms_sw,
    input logic             tms_core,
    input logic             tdo,
    input tap_state_e       state_q,
    input logic [SEL_W-1:0] sel_q
);

    AST_ONE_TARGET: assert property (@(posedge tck) disable iff (!trst_n)
        $countones({~tms_sw, ~tms_core}) <= 1); // R5

    AST_SEL_HELD_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == TS_SHIFT_DR) |=> $stable(sel_q)); // R4

    AST_RESET_CLEARS_SEL: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == TS_RESET) |-> (sel_q == '0)); // R2

    AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
        ((sel_q == '0) && (state_q != TS_SHIFT_IR) && (state_q != TS_SHIFT_DR)) |-> !tdo); // R9

    AST_ROUTE_STICKY: assert property (@(posedge tck) disable iff (!trst_n)
        (sel_q[SEL_W-1] || (sel_q == SEL_W'(1))) |=> ((sel_q == $past(sel_q)) || (sel_q == '0))); // R10

endmodule

bind jtag_route_mux jtag_route_chk #(.SEL_W(SEL_W)) u_chk (
    .tck      (tck),
    .trst_n   (trst_n),
    .tms_sw   (tms_sw),
    .tms_core (tms_core),
    .tdo      (tdo),
    .state_q  (tap_state),
    .sel_q    (sel_cur)
);

// File: tb/jtag_route_mux_tb.sv
module jtag_route_mux_tb;

    localparam logic [3:0] OPC_ROUTE = 4'h2;
    localparam logic [3:0] OPC_BYP   = 4'hF;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b0;
    logic tdi = 1'b0;
    logic tdo_sw = 1'b0;
    logic tdo_core = 1'b0;
    logic tms_sw, tms_core, tdo;

    int   checks = 0;
    int   errors = 0;
    int   exp_route = 0;   // 0 none, 1 switch, 2 core
    bit   in_shift = 1'b0;
    bit   done = 1'b0;
    logic [7:0] lf = 8'hA5;
    logic [7:0] cap;
    logic       b;

    always #4 tck = ~tck;

    jtag_route_mux u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo_sw(tdo_sw), .tdo_core(tdo_core),
        .tms_sw(tms_sw), .tms_core(tms_core), .tdo(tdo)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // one tck cycle: drive at falling edge, compare the routing model, leave after rising edge
    task automatic clk(input logic m, input logic d, output logic so);
        @(negedge tck);
        tms = m;
        tdi = d;
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        tdo_sw = lf[0];
        tdo_core = lf[1];
        #2;
        check("R5 tms_sw", {7'd0, tms_sw}, {7'd0, (exp_route == 1) ? tms : 1'b1});
        check("R6 tms_core", {7'd0, tms_core}, {7'd0, (exp_route == 2) ? tms : 1'b1});
        if (exp_route == 1)      check("R5 tdo", {7'd0, tdo}, {7'd0, tdo_sw});
        else if (exp_route == 2) check("R6 tdo", {7'd0, tdo}, {7'd0, tdo_core});
        else if (!in_shift)      check("R9 tdo", {7'd0, tdo}, 8'd0);
        so = tdo;
        @(posedge tck);
    endtask

    task automatic shift_ir(input logic [3:0] val, output logic [3:0] c);
        logic x;
        clk(1, 0, x); clk(1, 0, x); clk(0, 0, x); clk(0, 0, x);
        in_shift = 1'b1;
        for (int i = 0; i < 4; i++) begin
            clk(i == 3, val[i], x);
            c[i] = x;
        end
        in_shift = 1'b0;
        clk(1, 0, x); clk(0, 0, x);
    endtask

    task automatic shift_dr(input logic [7:0] val, input int n, output logic [7:0] c);
        logic x;
        c = '0;
        clk(1, 0, x); clk(0, 0, x); clk(0, 0, x);
        in_shift = 1'b1;
        for (int i = 0; i < n; i++) begin
            clk(i == n - 1, val[i], x);
            c[i] = x;
        end
        in_shift = 1'b0;
        clk(1, 0, x); clk(0, 0, x);
    endtask

    // from Run-Test/Idle: Test-Logic-Reset is entered on the third high cycle
    task automatic tlr_reset();
        logic x;
        for (int i = 0; i < 5; i++) begin
            clk(1, 0, x);
            if (i == 2) exp_route = 0;
        end
        clk(0, 0, x);
    endtask

    initial begin
        logic [3:0] ci;
        repeat (3) @(negedge tck);
        #2;
        check("R1 tms_sw in reset", {7'd0, tms_sw}, 8'd1);
        check("R1 tms_core in reset", {7'd0, tms_core}, 8'd1);
        check("R1 tdo in reset", {7'd0, tdo}, 8'd0);
        @(negedge tck);
        trst_n = 1'b1;
        clk(0, 0, b); clk(0, 0, b);

        // R3: capture pattern and bypass register
        shift_ir(OPC_BYP, ci);
        check("R3 IR capture", {4'd0, ci}, 8'h01);
        shift_dr(8'b1011_0010, 8, cap);
        check("R3 bypass delay", cap, 8'b0110_0100);

        // R8 readback, R7 unassigned code
        shift_ir(OPC_ROUTE, ci);
        check("R3 IR capture 2", {4'd0, ci}, 8'h01);
        shift_dr(8'h06, 4, cap);
        check("R8 readback reset value", cap, 8'h00);
        shift_dr(8'h03, 4, cap);
        check("R8 readback 0110 (R7 idle)", cap, 8'h06);
        shift_dr(8'h01, 4, cap);
        check("R8 readback 0011", cap, 8'h03);
        exp_route = 1;   // R5, applied when Update-DR is left (R4)
        repeat (3) clk(0, 0, b);

        // R10: writes while routed are ignored
        shift_dr(8'h08, 4, cap);
        shift_dr(8'h00, 4, cap);
        repeat (2) clk(0, 0, b);

        // R2: five high cycles from Shift-DR
        clk(1, 0, b); clk(0, 0, b); clk(0, 0, b);
        for (int i = 0; i < 5; i++) clk(1, 0, b);
        exp_route = 0;
        clk(0, 0, b);
        shift_dr(8'h05, 3, cap);
        check("R2 IR back to bypass", cap, 8'h02);

        // R6: core with various low bits
        shift_ir(OPC_ROUTE, ci);
        shift_dr(8'h08, 4, cap);
        check("R8 readback after reset", cap, 8'h00);
        exp_route = 2;
        repeat (2) clk(0, 0, b);
        tlr_reset();
        shift_ir(OPC_ROUTE, ci);
        shift_dr(8'h0D, 4, cap);
        exp_route = 2;   // R6 low bits ignored
        repeat (2) clk(0, 0, b);
        tlr_reset();
        shift_ir(OPC_ROUTE, ci);
        shift_dr(8'h07, 4, cap);
        check("R8 readback clean", cap, 8'h00);
        shift_dr(8'h0F, 4, cap);
        check("R8 readback 0111 (R7 idle)", cap, 8'h07);
        exp_route = 2;
        repeat (2) clk(0, 0, b);

        // R1: asynchronous reset while routed
        @(negedge tck);
        trst_n = 1'b0;
        #2;
        exp_route = 0;
        check("R1 tms_core after trst", {7'd0, tms_core}, 8'd1);
        check("R1 tdo after trst", {7'd0, tdo}, 8'd0);
        @(negedge tck);
        trst_n = 1'b1;
        clk(0, 0, b); clk(0, 0, b);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule